// File: doc/BRIEF.md
# 16-bit Capture/Compare Timer

This block is a 16-bit timer/counter with two capture/compare channels, sitting on a word-wide register bus. The counter advances on one of four single-cycle tick enables chosen in its control register. It can stop, count up to a period held in channel 0, or run freely through the whole 16-bit range. Each wrap can raise an overflow interrupt.

Each channel works in one of two modes. As a capture unit, it watches one of four inputs (its A pin, its B pin, constant low, constant high) and latches the counter on a rising edge, a falling edge or both. Because the two constant inputs can be selected, software can force a capture by switching the input select. As a compare unit, it raises its flag when the counter steps onto its value and drives its output pin in one of several ways. Two of these are PWM modes that pair the channel's own match with the channel 0 period match.

Channel 0 has a dedicated interrupt line. Channel 1 and the counter overflow share a second line through a priority vector register, and reading that register acknowledges the source it reports.

Top module: `cctimer16`

## Requirements
- R1: After synchronous reset the counter, both channel values and all control words read 0, `cc_out`, `irq_ch0` and `irq_vec` are 0, and the vector register reads 0. Register word addresses are: timer control 0x160, channel 0 control 0x162, channel 1 control 0x164, counter 0x170, channel 0 value 0x172, channel 1 value 0x174, vector 0x12E. `bus_rdata` shows the addressed register in the same cycle.
- R2: Timer control bits [1:0] pick the tick enable that advances the counter: 0 `tick_ext`, 1 `tick_aux`, 2 `tick_smc`, 3 `tick_alt`. The counter advances by one on each cycle in which the picked enable is high. The other three enables have no effect, and run mode 0 (bits [3:2]) holds the counter.
- R3: In up mode (bits [3:2] = 1) the counter counts 0 up to the channel 0 value. The next advance takes it to 0, which sets overflow flag bit 6. A counter already above the channel 0 value also goes to 0 on its next advance.
- R4: In continuous mode (bits [3:2] = 2) the counter counts up to 0xFFFF. The next advance takes it to 0 and sets bit 6. Mode 3 holds the counter like mode 0.
- R5: Writing timer control with bit 4 set clears the counter, and bit 4 always reads 0. Writing the counter address loads the counter. Neither a load nor a clear causes a compare match.
- R6: A channel whose control bit 4 is 1 captures. Bits [1:0] pick the edge: 1 rising, 2 falling, 3 both, 0 none. Bits [3:2] pick the input: 0 pin A, 1 pin B, 2 low, 3 high. On the picked edge of the picked input, the channel value takes the counter value of that cycle and flag bit 10 is set. Edges on unselected inputs have no effect.
- R7: A capture that occurs while the channel flag is already set also sets capture-overrun bit 11.
- R8: A channel in compare mode (bit 4 = 0) sets flag bit 10 when an advance brings the counter to its value. Output mode bits [7:5] then act on the match: 1 set, 2 toggle, 3 reset. Mode 0 drives the output from bit 8.
- R9: Output mode 4 sets the output on the channel's own match and clears it on a channel 0 match. Mode 5 clears it on its own match and sets it on a channel 0 match. The own match takes priority.
- R10: `irq_ch0` is high exactly while channel 0 flag (bit 10) and enable (bit 9) are both set. Channel 0 is never reported through the vector.
- R11: The vector register reads 2 when the channel 1 flag and enable are set. Otherwise it reads 10 when overflow flag bit 6 and its enable bit 5 are set. Otherwise it reads 0. `irq_vec` is high whenever the vector is nonzero.
- R12: A bus read of the vector register clears only the flag it reports. A hardware set of that flag in the same cycle wins, and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 9 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per word |
| bus_rd | input | 1 | Read strobe, qualifies read side effects |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| tick_ext | input | 1 | Counter tick enable, source 0 |
| tick_aux | input | 1 | Counter tick enable, source 1 |
| tick_smc | input | 1 | Counter tick enable, source 2 |
| tick_alt | input | 1 | Counter tick enable, source 3 |
| cap_a | input | 2 | Capture input A per channel |
| cap_b | input | 2 | Capture input B per channel |
| cc_out | output | 2 | Channel outputs |
| irq_ch0 | output | 1 | Channel 0 interrupt |
| irq_vec | output | 1 | Shared interrupt for channel 1 and overflow |

## Verification
The risky collision is an acknowledging read of the vector register in the same cycle as a new hardware set of the flag that read is clearing. The bench provokes it by parking the counter at 0xFFFF with channel 1 matching at 0, then issuing the vector read with the tick enable high in that same cycle, so that a wrap and a channel 1 match land on the acknowledge edge. It judges the outcome by reading the vector again: it must still report channel 1, then overflow, then nothing. A lost set would show up as an early overflow or zero code.

// File: rtl/cctimer_pkg.sv
package cctimer_pkg;

    localparam int DW  = 16;   // register and counter width
    localparam int AW  = 9;    // bus byte address width
    localparam int NCH = 2;    // capture/compare channels

    localparam logic [AW-1:0] A_TCTL     = 9'h160;
    localparam logic [AW-1:0] A_CCTL_BASE = 9'h162;
    localparam logic [AW-1:0] A_CNT      = 9'h170;
    localparam logic [AW-1:0] A_CVAL_BASE = 9'h172;
    localparam logic [AW-1:0] A_IVEC     = 9'h12E;

    localparam logic [DW-1:0] IV_NONE = 16'd0;
    localparam logic [DW-1:0] IV_CH1  = 16'd2;
    localparam logic [DW-1:0] IV_OVF  = 16'd10;

    typedef enum logic [1:0] {
        SRC_EXT = 2'd0,
        SRC_AUX = 2'd1,
        SRC_SMC = 2'd2,
        SRC_ALT = 2'd3
    } clk_src_e;

    typedef enum logic [1:0] {
        RM_STOP = 2'd0,
        RM_UP   = 2'd1,
        RM_CONT = 2'd2,
        RM_HALT = 2'd3
    } run_mode_e;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_BOTH = 2'd3
    } edge_e;

    typedef enum logic [1:0] {
        IN_A    = 2'd0,
        IN_B    = 2'd1,
        IN_LOW  = 2'd2,
        IN_HIGH = 2'd3
    } insel_e;

    typedef enum logic [2:0] {
        OM_LEVEL  = 3'd0,
        OM_SET    = 3'd1,
        OM_TOGGLE = 3'd2,
        OM_RESET  = 3'd3,
        OM_SETRST = 3'd4,
        OM_RSTSET = 3'd5,
        OM_RSV6   = 3'd6,
        OM_RSV7   = 3'd7
    } outmode_e;

    // timer control, packed in bus bit order from bit 6 down to bit 0
    typedef struct packed {
        logic      ovf;    // bit 6
        logic      ovie;   // bit 5
        logic      clr;    // bit 4, never stored as 1
        run_mode_e mode;   // bits 3:2
        clk_src_e  src;    // bits 1:0
    } tmr_ctl_t;

    // channel control, packed in bus bit order from bit 11 down to bit 0
    typedef struct packed {
        logic     cov;     // bit 11
        logic     flag;    // bit 10
        logic     ie;      // bit 9
        logic     outval;  // bit 8
        outmode_e om;      // bits 7:5
        logic     capmode; // bit 4
        insel_e   sel;     // bits 3:2
        edge_e    edg;     // bits 1:0
    } cc_ctl_t;

    localparam int TCW = $bits(tmr_ctl_t);
    localparam int CCW = $bits(cc_ctl_t);

    function automatic logic [AW-1:0] cctl_addr(input int idx);
        return A_CCTL_BASE + AW'(2 * idx);
    endfunction

    function automatic logic [AW-1:0] cval_addr(input int idx);
        return A_CVAL_BASE + AW'(2 * idx);
    endfunction

endpackage

// File: rtl/cct_counter.sv
module cct_counter
    import cctimer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  run_mode_e       mode,
    input  clk_src_e        src,
    input  logic [3:0]      src_ticks,
    input  logic [W-1:0]    period,
    input  logic            ld,
    input  logic [W-1:0]    ld_val,
    input  logic            clr,
    output logic [W-1:0]    cnt,
    output logic [W-1:0]    cnt_next,
    output logic            adv,
    output logic            wrap
);

    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic running;

    assign running = (mode == RM_UP) || (mode == RM_CONT);
    assign adv     = src_ticks[src] && running && !ld && !clr;

    always_comb begin
        cnt_next = cnt;
        wrap     = 1'b0;
        if (adv) begin
            if ((mode == RM_UP) && (cnt >= period)) begin
                cnt_next = '0;
                wrap     = 1'b1;
            end else if (cnt == CNT_MAX) begin
                cnt_next = '0;
                wrap     = 1'b1;
            end else begin
                cnt_next = cnt + W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (ld) begin
            cnt <= ld_val;
        end else if (clr) begin
            cnt <= '0;
        end else begin
            cnt <= cnt_next;
        end
    end

    // R2: without an advance, load or clear the count holds
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!adv && !ld && !clr) |=> (cnt == $past(cnt)));

    // R3: up mode returns to zero once the period is reached
    assert_up_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (adv && mode == RM_UP && cnt >= period) |=> (cnt == '0));

    // R4: continuous mode rolls from all ones to zero
    assert_cont_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (adv && mode == RM_CONT && cnt == CNT_MAX) |=> (cnt == '0));

    // R5: a load wins over counting
    assert_load_R5: assert property (@(posedge clk) disable iff (rst)
        ld |=> (cnt == $past(ld_val)));

endmodule

// File: rtl/cct_channel.sv
module cct_channel
    import cctimer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [W-1:0]    cnt_cur,
    input  logic [W-1:0]    cnt_next,
    input  logic            adv,
    input  logic            period_evt,
    input  logic            in_a,
    input  logic            in_b,
    input  logic            ctl_we,
    input  logic            val_we,
    input  logic [DW-1:0]   wdata,
    input  logic            vec_clr,
    output cc_ctl_t         ctl,
    output logic [W-1:0]    val,
    output logic            match,
    output logic            out
);

    logic sel_in;
    logic prev_in;
    logic rise;
    logic fall;
    logic cap_evt;

    always_comb begin
        unique case (ctl.sel)
            IN_A:    sel_in = in_a;
            IN_B:    sel_in = in_b;
            IN_LOW:  sel_in = 1'b0;
            default: sel_in = 1'b1;
        endcase
    end

    assign rise    = sel_in && !prev_in;
    assign fall    = !sel_in && prev_in;
    assign cap_evt = ctl.capmode &&
                     ((ctl.edg[0] && rise) || (ctl.edg[1] && fall));
    assign match   = !ctl.capmode && adv && (cnt_next == val);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_in <= 1'b0;
        end else begin
            prev_in <= sel_in;
        end
    end

    // control word: software write first, hardware sets take the last word
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else begin
            if (ctl_we) begin
                ctl <= cc_ctl_t'(wdata[CCW-1:0]);
            end else if (vec_clr) begin
                ctl.flag <= 1'b0;
            end
            if (cap_evt) begin
                ctl.flag <= 1'b1;
                if (ctl.flag) begin
                    ctl.cov <= 1'b1;
                end
            end
            if (match) begin
                ctl.flag <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            val <= '0;
        end else if (cap_evt) begin
            val <= cnt_cur;
        end else if (val_we) begin
            val <= wdata[W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out <= 1'b0;
        end else begin
            unique case (ctl.om)
                OM_SET:    if (match) out <= 1'b1;
                OM_TOGGLE: if (match) out <= !out;
                OM_RESET:  if (match) out <= 1'b0;
                OM_SETRST: begin
                    if (match)           out <= 1'b1;
                    else if (period_evt) out <= 1'b0;
                end
                OM_RSTSET: begin
                    if (match)           out <= 1'b0;
                    else if (period_evt) out <= 1'b1;
                end
                default:   out <= ctl.outval;
            endcase
        end
    end

    // R6: a capture stores the count seen in its cycle
    assert_cap_val_R6: assert property (@(posedge clk) disable iff (rst)
        cap_evt |=> (val == $past(cnt_cur)));

    // R7: capturing over a pending flag marks an overrun
    assert_cap_ovr_R7: assert property (@(posedge clk) disable iff (rst)
        (cap_evt && ctl.flag) |=> ctl.cov);

    // R8: a compare match always leaves the flag set
    assert_match_flag_R8: assert property (@(posedge clk) disable iff (rst)
        match |=> ctl.flag);

    // R8: toggle mode flips the pin on a match
    assert_toggle_R8: assert property (@(posedge clk) disable iff (rst)
        (match && ctl.om == OM_TOGGLE) |=> (out != $past(out)));

endmodule

// File: rtl/cctimer16.sv
module cctimer16
    import cctimer_pkg::*;
#(
    parameter int CW = cctimer_pkg::DW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic            tick_ext,
    input  logic            tick_aux,
    input  logic            tick_smc,
    input  logic            tick_alt,
    input  logic [NCH-1:0]  cap_a,
    input  logic [NCH-1:0]  cap_b,
    output logic [NCH-1:0]  cc_out,
    output logic            irq_ch0,
    output logic            irq_vec
);

    tmr_ctl_t        tctl;
    logic [CW-1:0]   cnt;
    logic [CW-1:0]   cnt_next;
    logic            adv;
    logic            wrap;
    logic            cnt_ld;
    logic            cnt_clr;
    logic            tctl_we;
    logic [3:0]      src_ticks;

    cc_ctl_t         ch_ctl   [NCH];
    logic [CW-1:0]   ch_val   [NCH];
    logic [NCH-1:0]  ch_match;
    logic [NCH-1:0]  ch_ctl_we;
    logic [NCH-1:0]  ch_val_we;
    logic [NCH-1:0]  ch_vclr;

    logic [DW-1:0]   ivec;
    logic            rd_vec;
    logic            ack_ch1;
    logic            ack_ovf;

    assign src_ticks = {tick_alt, tick_smc, tick_aux, tick_ext};
    assign tctl_we   = bus_wr && (bus_addr == A_TCTL);
    assign cnt_ld    = bus_wr && (bus_addr == A_CNT);
    assign cnt_clr   = tctl_we && bus_wdata[4];

    cct_counter #(.W(CW)) i_counter (
        .clk       (clk),
        .rst       (rst),
        .mode      (tctl.mode),
        .src       (tctl.src),
        .src_ticks (src_ticks),
        .period    (ch_val[0]),
        .ld        (cnt_ld),
        .ld_val    (bus_wdata[CW-1:0]),
        .clr       (cnt_clr),
        .cnt       (cnt),
        .cnt_next  (cnt_next),
        .adv       (adv),
        .wrap      (wrap)
    );

    // timer control: the clear bit is a strobe and is never kept
    always_ff @(posedge clk) begin
        if (rst) begin
            tctl <= '0;
        end else begin
            if (tctl_we) begin
                tctl     <= tmr_ctl_t'(bus_wdata[TCW-1:0]);
                tctl.clr <= 1'b0;
            end else if (ack_ovf) begin
                tctl.ovf <= 1'b0;
            end
            if (wrap) begin
                tctl.ovf <= 1'b1;
            end
        end
    end

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_ch
            assign ch_ctl_we[g] = bus_wr && (bus_addr == cctl_addr(g));
            assign ch_val_we[g] = bus_wr && (bus_addr == cval_addr(g));
            if (g == 1) begin : g_vec_src
                assign ch_vclr[g] = ack_ch1;
            end else begin : g_own_irq
                assign ch_vclr[g] = 1'b0;
            end

            cct_channel #(.W(CW)) i_chan (
                .clk        (clk),
                .rst        (rst),
                .cnt_cur    (cnt),
                .cnt_next   (cnt_next),
                .adv        (adv),
                .period_evt (ch_match[0]),
                .in_a       (cap_a[g]),
                .in_b       (cap_b[g]),
                .ctl_we     (ch_ctl_we[g]),
                .val_we     (ch_val_we[g]),
                .wdata      (bus_wdata),
                .vec_clr    (ch_vclr[g]),
                .ctl        (ch_ctl[g]),
                .val        (ch_val[g]),
                .match      (ch_match[g]),
                .out        (cc_out[g])
            );
        end
    endgenerate

    // priority vector: channel 1 ahead of overflow
    always_comb begin
        if (ch_ctl[1].flag && ch_ctl[1].ie) begin
            ivec = IV_CH1;
        end else if (tctl.ovf && tctl.ovie) begin
            ivec = IV_OVF;
        end else begin
            ivec = IV_NONE;
        end
    end

    assign rd_vec  = bus_rd && (bus_addr == A_IVEC);
    assign ack_ch1 = rd_vec && (ivec == IV_CH1);
    assign ack_ovf = rd_vec && (ivec == IV_OVF);

    assign irq_ch0 = ch_ctl[0].flag && ch_ctl[0].ie;
    assign irq_vec = (ivec != IV_NONE);

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_TCTL) begin
            bus_rdata = {{(DW-TCW){1'b0}}, tctl};
        end else if (bus_addr == A_CNT) begin
            bus_rdata = DW'(cnt);
        end else if (bus_addr == A_IVEC) begin
            bus_rdata = ivec;
        end
        for (int i = 0; i < NCH; i++) begin
            if (bus_addr == cctl_addr(i)) begin
                bus_rdata = {{(DW-CCW){1'b0}}, ch_ctl[i]};
            end
            if (bus_addr == cval_addr(i)) begin
                bus_rdata = DW'(ch_val[i]);
            end
        end
    end

    // R12: acknowledging overflow clears it unless a wrap lands on that edge
    assert_ack_ovf_R12: assert property (@(posedge clk) disable iff (rst)
        (ack_ovf && !wrap && !tctl_we) |=> !tctl.ovf);

    // R12: a wrap during the acknowledge keeps the flag
    assert_set_wins_R12: assert property (@(posedge clk) disable iff (rst)
        wrap |=> tctl.ovf);

    // R5: the clear strobe is never held in the control word
    assert_clr_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        tctl_we |=> !tctl.clr);

    // R11: the vector line and the code agree, channel 0 excluded
    assert_vec_line_R11: assert property (@(posedge clk) disable iff (rst)
        (!ch_ctl[1].ie && !tctl.ovie) |-> !irq_vec);

endmodule

// File: tb/test_cctimer16.sv
module test_cctimer16;

    localparam logic [8:0] T_CTL  = 9'h160;
    localparam logic [8:0] C0_CTL = 9'h162;
    localparam logic [8:0] C1_CTL = 9'h164;
    localparam logic [8:0] T_CNT  = 9'h170;
    localparam logic [8:0] C0_VAL = 9'h172;
    localparam logic [8:0] C1_VAL = 9'h174;
    localparam logic [8:0] T_VEC  = 9'h12E;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [8:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [3:0]  tk = '0;
    logic [1:0]  cap_a = '0;
    logic [1:0]  cap_b = '0;
    logic [1:0]  cc_out;
    logic        irq_ch0;
    logic        irq_vec;

    int checks = 0;
    int errors = 0;
    bit smp = 1'b0;
    bit done = 1'b0;

    logic [15:0] exp_q[$];
    bit          kind_q[$];
    string       tag_q[$];

    always #10 clk = !clk;

    cctimer16 i_cctimer16 (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tick_ext  (tk[0]),
        .tick_aux  (tk[1]),
        .tick_smc  (tk[2]),
        .tick_alt  (tk[3]),
        .cap_a     (cap_a),
        .cap_b     (cap_b),
        .cc_out    (cc_out),
        .irq_ch0   (irq_ch0),
        .irq_vec   (irq_vec)
    );

    // monitor: pops the expected item for each sample strobe
    always @(negedge clk) begin
        if (smp && exp_q.size() > 0) begin
            logic [15:0] e;
            logic [15:0] a;
            bit k;
            string t;
            e = exp_q.pop_front();
            k = kind_q.pop_front();
            t = tag_q.pop_front();
            a = k ? {12'h000, irq_vec, irq_ch0, cc_out} : bus_rdata;
            checks++;
            if (a !== e) begin
                errors++;
                $display("FAIL %s: actual 0x%04h expected 0x%04h", t, a, e);
            end
        end
    end

    task automatic wr(input logic [8:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, input logic [15:0] e,
                      input string t, input bit with_tick);
        @(posedge clk); #1;
        bus_addr = a; bus_rd = 1'b1; tk[2] = with_tick;
        exp_q.push_back(e); kind_q.push_back(1'b0); tag_q.push_back(t);
        smp = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0; tk[2] = 1'b0; smp = 1'b0;
    endtask

    // pins word = {irq_vec, irq_ch0, cc_out[1], cc_out[0]}
    task automatic pins(input logic [3:0] e, input string t);
        @(posedge clk); #1;
        exp_q.push_back({12'h000, e}); kind_q.push_back(1'b1); tag_q.push_back(t);
        smp = 1'b1;
        @(posedge clk); #1;
        smp = 1'b0;
    endtask

    task automatic pulse(input int src, input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1;
            tk[src] = 1'b1;
            @(posedge clk); #1;
            tk = '0;
        end
    endtask

    task automatic set_a(input int ch, input logic v);
        @(posedge clk); #1;
        cap_a[ch] = v;
    endtask

    task automatic set_b(input int ch, input logic v);
        @(posedge clk); #1;
        cap_b[ch] = v;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // reset state
        rd(T_CTL,  16'h0000, "R1 timer control", 0);
        rd(T_CNT,  16'h0000, "R1 counter", 0);
        rd(C0_CTL, 16'h0000, "R1 channel 0 control", 0);
        rd(T_VEC,  16'h0000, "R1 vector", 0);
        pins(4'b0000, "R1 pins");

        // source select: tick_smc, continuous
        wr(T_CTL, 16'h000A);
        pulse(0, 3);
        rd(T_CNT, 16'h0000, "R2 unselected tick ignored", 0);
        pulse(2, 5);
        rd(T_CNT, 16'h0005, "R2 selected tick counts", 0);
        wr(T_CTL, 16'h0002);
        pulse(2, 2);
        rd(T_CNT, 16'h0005, "R2 stop mode holds", 0);

        // clear strobe and load
        wr(T_CTL, 16'h0012);
        rd(T_CNT, 16'h0000, "R5 clear", 0);
        rd(T_CTL, 16'h0002, "R5 clear bit reads 0", 0);
        wr(T_CNT, 16'hFFFD);
        rd(T_CNT, 16'hFFFD, "R5 load", 0);

        // continuous wrap with overflow interrupt enabled
        wr(T_CTL, 16'h002A);
        pulse(2, 2);
        rd(T_CTL, 16'h002A, "R4 no flag before wrap", 0);
        pulse(2, 1);
        rd(T_CNT, 16'h0000, "R4 wrap to zero", 0);
        rd(T_CTL, 16'h006A, "R4 overflow flag", 0);
        pins(4'b1000, "R11 overflow line");
        rd(T_VEC, 16'd10, "R11 overflow code", 0);
        rd(T_VEC, 16'd0, "R12 overflow acknowledged", 0);
        rd(T_CTL, 16'h002A, "R12 flag cleared", 0);
        wr(T_CTL, 16'h000E);
        pulse(2, 2);
        rd(T_CNT, 16'h0000, "R4 mode 3 holds", 0);

        // up mode, period 3
        wr(C0_VAL, 16'h0003);
        wr(T_CTL, 16'h0016);
        pulse(2, 3);
        rd(T_CNT, 16'h0003, "R3 reaches period", 0);
        rd(T_CTL, 16'h0006, "R3 no flag at period", 0);
        pulse(2, 1);
        rd(T_CNT, 16'h0000, "R3 wraps after period", 0);
        rd(T_CTL, 16'h0046, "R3 overflow flag", 0);
        wr(C0_CTL, 16'h0600);
        pins(4'b0100, "R10 channel 0 line");
        wr(C0_CTL, 16'h0200);
        pins(4'b0000, "R10 line drops with flag");
        pulse(2, 3);
        pins(4'b0100, "R10 match raises line");
        rd(C0_CTL, 16'h0600, "R8 channel 0 match flag", 0);

        // compare outputs on channel 1
        wr(C0_CTL, 16'h0000);
        wr(T_CTL, 16'h001A);
        wr(C1_VAL, 16'h0002);
        wr(C1_CTL, 16'h0040);
        pulse(2, 2);
        rd(C1_CTL, 16'h0440, "R8 channel 1 match flag", 0);
        pins(4'b0010, "R8 toggle");
        wr(C1_CTL, 16'h0000);
        pins(4'b0000, "R8 level low");
        wr(C1_CTL, 16'h0100);
        pins(4'b0010, "R8 level high");
        wr(C1_CTL, 16'h0060);
        wr(T_CNT, 16'h0001);
        pulse(2, 1);
        pins(4'b0000, "R8 reset on match");
        wr(C1_CTL, 16'h0020);
        wr(T_CNT, 16'h0001);
        pulse(2, 1);
        pins(4'b0010, "R8 set on match");

        // PWM, period 4, duty point 2
        wr(C0_VAL, 16'h0004);
        wr(T_CTL, 16'h0016);
        wr(C1_CTL, 16'h0000);
        wr(C1_CTL, 16'h0080);
        pulse(2, 1);
        pins(4'b0000, "R9 mode 4 low before match");
        pulse(2, 1);
        pins(4'b0010, "R9 mode 4 set at own match");
        pulse(2, 2);
        pins(4'b0000, "R9 mode 4 reset at period");
        wr(C1_CTL, 16'h00A0);
        pulse(2, 3);
        pulse(2, 2);
        pins(4'b0010, "R9 mode 5 set at period");
        pulse(2, 3);
        pins(4'b0000, "R9 mode 5 reset at own match");

        // capture
        wr(T_CTL, 16'h0012);
        wr(T_CNT, 16'h1234);
        wr(C0_CTL, 16'h0011);
        set_a(0, 1'b1);
        rd(C0_VAL, 16'h1234, "R6 rising capture", 0);
        rd(C0_CTL, 16'h0411, "R6 capture flag", 0);
        wr(T_CNT, 16'h0055);
        set_a(0, 1'b0);
        set_a(0, 1'b1);
        rd(C0_VAL, 16'h0055, "R7 second capture", 0);
        rd(C0_CTL, 16'h0C11, "R7 overrun bit", 0);
        wr(T_CNT, 16'h0077);
        wr(C1_CTL, 16'h001F);
        rd(C1_VAL, 16'h0077, "R6 select high captures", 0);
        rd(C1_CTL, 16'h041F, "R6 channel 1 flag", 0);
        wr(T_CNT, 16'h0088);
        wr(C1_CTL, 16'h001B);
        rd(C1_VAL, 16'h0088, "R6 select low falls", 0);
        rd(C1_CTL, 16'h041B, "R7 no overrun after clear", 0);
        wr(T_CNT, 16'h0099);
        wr(C0_CTL, 16'h0015);
        set_a(0, 1'b0);
        set_a(0, 1'b1);
        rd(C0_VAL, 16'h0055, "R6 input A ignored when B selected", 0);
        set_b(0, 1'b1);
        rd(C0_VAL, 16'h0099, "R6 input B capture", 0);
        rd(C0_CTL, 16'h0415, "R6 input B flag", 0);

        // vector priority and acknowledge
        wr(C1_CTL, 16'h0200);
        wr(C1_VAL, 16'h0000);
        wr(T_CNT, 16'hFFFF);
        wr(T_CTL, 16'h002A);
        pulse(2, 1);
        pins(4'b1000, "R11 shared line");
        rd(T_VEC, 16'd2, "R11 channel 1 first", 0);
        rd(T_VEC, 16'd10, "R12 only channel 1 cleared", 0);
        rd(T_VEC, 16'd0, "R12 all acknowledged", 0);
        pins(4'b0000, "R11 line low");

        // acknowledge colliding with a new set
        wr(T_CNT, 16'hFFFF);
        pulse(2, 1);
        wr(T_CNT, 16'hFFFF);
        rd(T_VEC, 16'd2, "R12 vector before collision", 1);
        rd(T_VEC, 16'd2, "R12 set wins over acknowledge", 0);
        rd(T_VEC, 16'd10, "R12 overflow after collision", 0);
        rd(T_VEC, 16'd0, "R12 vector empty", 0);

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule